// File: doc/BRIEF.md
# PCM Sample to Single-Precision Float Converter

This block turns a 16-bit audio sample into an IEEE-754 single-precision word. A mode input picks the meaning of the sample. With the mode high, the sample is two's complement and the result is the sample times 2^-15, so the output spans -1.0 up to just under +1.0. With the mode low, the sample is unsigned and the result is the sample times 2^-16, so the output spans 0.0 up to just under 1.0. The significand is 24 bits wide, so every sample fits without rounding, and no result is ever denormal.

The datapath is combinational. When the sample is negative, the datapath forms its magnitude. A leading-one detector gives the position p of the top set bit. The exponent is a fixed bias plus p. The magnitude is shifted left so that bit p lands on the hidden-bit position, and the bits below it become the fraction. Two cases bypass this path. A zero sample gives an all-zero word in both modes. The most negative signed sample gives a constant -1.0.

A small state machine registers the result. It has two states: `ST_IDLE` (no result this cycle) and `ST_EMIT` (a fresh result is on the output). The state changes on every clock edge:
- `in_valid` high moves the machine to `ST_EMIT`, from either state.
- `in_valid` low moves it to `ST_IDLE`, from either state.

The output word changes only on a cycle with `in_valid` high. Otherwise it keeps its last value.

Top module: `pcm_to_float`

## Requirements
- R1: A zero sample (0x0000) gives an output word of 0x00000000 in both modes.
- R2: In signed mode (`in_signed` = 1), the sample 0x8000 gives 0xBF800000, which is -1.0.
- R3: In signed mode, a sample with bit 15 set gives an output with bit 31 set. The value is minus the two's-complement magnitude times 2^-15.
- R4: In signed mode, a non-zero sample with bit 15 clear gives exactly sample × 2^-15, with bit 31 clear. The exponent field (bits 30:23) is 112 + p, where p is the leading-one position.
- R5: In unsigned mode (`in_signed` = 0), a non-zero sample gives exactly sample × 2^-16, with bit 31 clear. The exponent field is 111 + p, which always lies in 111..126.
- R6: The result for a sample appears one clock after the cycle in which `in_valid` is high, with `out_valid` high for that one cycle. After a cycle with `in_valid` low, `out_valid` is low and `out_float` is unchanged.
- R7: While reset is held and after reset, `out_valid` is 0 and `out_float` is 0x00000000, until the first valid sample.
- R8: The fraction field (bits 22:0) holds the magnitude bits below the leading one, placed at the top of the field, with zeros below them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Sample code |
| in_signed | input | 1 | 1 = two's complement (×2^-15), 0 = unsigned (×2^-16) |
| out_valid | output | 1 | High for one cycle when a new result is on `out_float` |
| out_float | output | 32 | Single-precision result |

## Verification
The assertions sample `in_data` and `in_signed` only in a cycle where `in_valid` is high. They assume both inputs hold known values whenever the strobe is set, and that reset is applied before the first sample. The stimulus meets these assumptions:
- It changes inputs only on the falling clock edge.
- It starts with reset held.
- It drives only defined codes, in three phases: the directed corners, a full sweep of all 65536 codes in each mode, and a seeded random phase.
- In the random phase about a quarter of the cycles have `in_valid` low, so the hold behaviour is exercised. The code and mode still change in those cycles.

// File: rtl/pcm_to_float_pkg.sv
package pcm_to_float_pkg;

    localparam int SIG_W  = 24;
    localparam int FRAC_W = 23;
    localparam int EXP_W  = 8;
    localparam int BIAS   = 127;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } sp_word_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_t;

endpackage

// File: rtl/pcm_magnitude.sv
module pcm_magnitude #(
    parameter int IN_W = 16
) (
    input  logic [IN_W-1:0] code,
    input  logic            negate,
    output logic [IN_W-1:0] mag
);
    // Invert and add one; the carry out of the top bit is dropped.
    always_comb begin
        if (negate) mag = ~code + IN_W'(1);
        else        mag = code;
    end
endmodule

// File: rtl/pcm_lead_one.sv
module pcm_lead_one #(
    parameter int IN_W = 16,
    localparam int PW  = $clog2(IN_W)
) (
    input  logic [IN_W-1:0] mag,
    output logic [PW-1:0]   pos
);
    logic [IN_W-1:0] above;
    logic [IN_W-1:0] hot;

    assign above[IN_W-1] = 1'b0;
    generate
        for (genvar g = IN_W - 2; g >= 0; g--) begin : g_chain
            assign above[g] = above[g+1] | mag[g+1];
        end
        for (genvar h = 0; h < IN_W; h++) begin : g_hot
            assign hot[h] = mag[h] & ~above[h];
        end
    endgenerate

    always_comb begin
        pos = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (hot[i]) pos = pos | PW'(i);
        end
    end
endmodule

// File: rtl/pcm_pack.sv
module pcm_pack
    import pcm_to_float_pkg::*;
#(
    parameter int IN_W = 16,
    localparam int PW  = $clog2(IN_W),
    localparam int BIAS_SGN = BIAS - (IN_W - 1),
    localparam int BIAS_UNS = BIAS - IN_W
) (
    input  logic [IN_W-1:0] mag,
    input  logic [PW-1:0]   pos,
    input  logic            neg,
    input  logic            is_signed,
    output sp_word_t        word
);
    logic [SIG_W-1:0] aligned;
    logic [EXP_W-1:0] bias_sel;

    always_comb begin
        aligned   = SIG_W'(mag) << (SIG_W - 1 - int'(pos));
        bias_sel  = is_signed ? EXP_W'(BIAS_SGN) : EXP_W'(BIAS_UNS);
        word.sign = neg;
        word.expo = bias_sel + EXP_W'(pos);
        word.frac = aligned[FRAC_W-1:0];
    end
endmodule

// File: rtl/pcm_to_float.sv
module pcm_to_float
    import pcm_to_float_pkg::*;
#(
    parameter int IN_W = 16,
    localparam int PW  = $clog2(IN_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_data,
    input  logic            in_signed,
    output logic            out_valid,
    output logic [31:0]     out_float
);
    localparam logic [31:0] NEG_ONE = {1'b1, EXP_W'(BIAS), {FRAC_W{1'b0}}};
    localparam logic [IN_W-1:0] MOST_NEG = {1'b1, {(IN_W-1){1'b0}}};

    logic            neg;
    logic            is_zero;
    logic            is_most_neg;
    logic [IN_W-1:0] mag;
    logic [PW-1:0]   pos;
    sp_word_t        packed_word;
    logic [31:0]     next_word;
    emit_state_t     state_q;
    emit_state_t     state_d;

    assign neg         = in_signed & in_data[IN_W-1];
    assign is_zero     = ~|in_data;
    assign is_most_neg = in_signed & (in_data == MOST_NEG);

    pcm_magnitude #(.IN_W(IN_W)) u_mag (
        .code   (in_data),
        .negate (neg),
        .mag    (mag)
    );

    pcm_lead_one #(.IN_W(IN_W)) u_lod (
        .mag (mag),
        .pos (pos)
    );

    pcm_pack #(.IN_W(IN_W)) u_pack (
        .mag       (mag),
        .pos       (pos),
        .neg       (neg),
        .is_signed (in_signed),
        .word      (packed_word)
    );

    always_comb begin
        if (is_zero)          next_word = '0;
        else if (is_most_neg) next_word = NEG_ONE;
        else                  next_word = packed_word;
    end

    // Next-state logic: a strobe always leads to EMIT, no strobe to IDLE.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            out_float <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) out_float <= next_word;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: out_valid = 1'b0;
            ST_EMIT: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end

    // R1
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == '0) |=> (out_float == 32'h0000_0000));

    // R2
    most_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_signed && in_data == MOST_NEG) |=> (out_float == 32'hBF80_0000));

    // R3
    neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_signed && in_data[IN_W-1]) |=> out_float[31]);

    // R5
    uns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_signed && in_data != '0) |=>
        (!out_float[31] && out_float[30:23] >= 8'd111 && out_float[30:23] <= 8'd126));

    // R6
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_float)));

endmodule

// File: tb/test_pcm_to_float.sv
`timescale 1ns/1ps
module test_pcm_to_float;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_signed = 1'b0;
    logic        out_valid;
    logic [31:0] out_float;

    int n_checks = 0;
    int n_fails  = 0;

    bit          pend_v = 1'b0;
    logic [15:0] pend_x = '0;
    bit          pend_s = 1'b0;
    logic [31:0] last_out = '0;

    always #5 clk = ~clk;

    pcm_to_float i_pcm_to_float (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_signed (in_signed),
        .out_valid (out_valid),
        .out_float (out_float)
    );

    // Reference from the real value of the sample.
    function automatic logic [31:0] ref_word(logic [15:0] x, bit s);
        real v;
        real a;
        int  e;
        int  m;
        bit  sg;
        if (s) v = $itor($signed(x)) / 32768.0;
        else   v = $itor(x) / 65536.0;
        if (v == 0.0) return 32'h0;
        sg = (v < 0.0);
        a  = sg ? -v : v;
        e  = 0;
        while (a >= 2.0) begin a = a / 2.0; e++; end
        while (a < 1.0)  begin a = a * 2.0; e--; end
        m = $rtoi((a - 1.0) * 8388608.0);
        return {sg, 8'(e + 127), 23'(m)};
    endfunction

    function automatic string tag_for(logic [15:0] x, bit s);
        if (x == 16'h0)              return "R1";
        if (s && x == 16'h8000)      return "R2";
        if (s && x[15])              return "R3";
        if (s)                       return "R4/R8";
        return "R5/R8";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic check_pending();
        logic [31:0] e;
        if (pend_v) begin
            e = ref_word(pend_x, pend_s);
            check("R6 out_valid after strobe", {31'b0, out_valid}, 32'd1);
            check(tag_for(pend_x, pend_s), out_float, e);
            last_out = e;
        end else begin
            check("R6 out_valid idle", {31'b0, out_valid}, 32'd0);
            check("R6 hold", out_float, last_out);
        end
    endtask

    task automatic step(input bit v, input logic [15:0] x, input bit s);
        @(negedge clk);
        check_pending();
        in_valid  = v;
        in_data   = x;
        in_signed = s;
        pend_v = v;
        pend_x = x;
        pend_s = s;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog R6: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R7: values during reset
        check("R7 reset valid", {31'b0, out_valid}, 32'd0);
        check("R7 reset word", out_float, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 after reset", out_float, 32'h0);

        // Directed corners
        step(1'b1, 16'h0000, 1'b1);   // R1
        step(1'b1, 16'h0000, 1'b0);   // R1
        step(1'b1, 16'h8000, 1'b1);   // R2
        step(1'b1, 16'hFFFF, 1'b1);   // R3
        step(1'b1, 16'h7FFF, 1'b1);   // R4
        step(1'b1, 16'h0001, 1'b1);   // R4
        step(1'b1, 16'h0001, 1'b0);   // R5
        step(1'b1, 16'hFFFF, 1'b0);   // R5
        step(1'b1, 16'h8000, 1'b0);   // R5
        step(1'b0, 16'h1234, 1'b1);   // R6 hold
        step(1'b0, 16'h0000, 1'b0);   // R6 hold
        step(1'b1, 16'h4000, 1'b1);   // R4

        // Exhaustive sweep, both modes
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 65536; c++) begin
                step(1'b1, 16'(c), s[0]);
            end
        end

        // Seeded random mix with idle cycles
        for (int k = 0; k < 4000; k++) begin
            step(($urandom % 4) != 0, 16'($urandom), 1'($urandom));
        end

        step(1'b0, 16'h0, 1'b0);
        step(1'b0, 16'h0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule